// File: doc/BRIEF.md
# Shifted-Operand Accumulator Adder Unit

This block is the execute-stage datapath of a fixed-point DSP for one instruction: add a memory operand to the accumulator after shifting that operand left. The shift amount is not part of the opcode. It is read at run time from the low four bits of a temporary register, so any shift from 0 to 15 can be used. The operand is extended to the accumulator width before it is shifted. A mode input selects whether that extension copies the sign bit or fills with zeros. A second mode input selects whether a signed overflow saturates the accumulator or lets the sum wrap.

Each cycle the surrounding pipeline presents an instruction word, the fetched data word and a valid strobe. When the strobe is high and the opcode matches, the block performs the add on the next rising clock edge. It also updates the carry flag and the sticky overflow flag on that edge. Operand address generation and the memory interface belong to other blocks. The block only checks that the instruction is this add. It accepts both the direct and the indirect addressing forms.

Top module: `shacc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `acc`, `carry` and `ov` become 0 on that edge.
- R2: With `valid_in` high and `instr[15:8]` equal to 8'h63, the add executes. This holds for the direct form (`instr[7]`=0, with `instr[6:0]` an address that does not affect the result) and for the indirect form (`instr[7]`=1, with bit 3 and bits 2:0 as register-select fields that do not affect the result).
- R3: When `valid_in` is low, or `instr[15:8]` differs from 8'h63, `acc` and `carry` keep their values.
- R4: The extended operand is shifted left by `treg[3:0]`. The bits `treg[15:4]` have no effect. Bits shifted above bit 31 are discarded.
- R5: With `sxm`=1 the 16-bit `data_in` is sign-extended to 32 bits before the shift. With `sxm`=0 it is zero-extended.
- R6: On each executed add, `carry` takes the carry-out of the unsigned 32-bit addition and is cleared when there is none. This holds even when the result saturates.
- R7: `ov` is set by an executed add that causes signed two's-complement overflow. Once set, it stays set until it is cleared.
- R8: `ov_clear` high at an edge clears `ov`, whether or not an add executes. If an overflowing add executes on the same edge, `ov` is set instead.
- R9: With `ovm`=1, a positive overflow loads 32'h7FFFFFFF into `acc` and a negative overflow loads 32'h80000000.
- R10: With `ovm`=0, an overflowing add stores the wrapped 32-bit sum.
- R11: The result of an accepted add is visible on `acc`, `carry` and `ov` right after the edge that accepts it. Adds on consecutive cycles accumulate without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Instruction and data word are valid this cycle |
| instr | input | 16 | Instruction word to decode |
| data_in | input | 16 | Data operand fetched for the instruction |
| treg | input | 16 | Temporary register; bits 3:0 give the shift |
| sxm | input | 1 | 1 = sign-extend the operand, 0 = zero-extend |
| ovm | input | 1 | 1 = saturate on overflow, 0 = wrap |
| ov_clear | input | 1 | Clears the sticky overflow flag |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry out of the last executed add |
| ov | output | 1 | Sticky overflow flag |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. This covers the accumulator, the carry, the overflow flag and its clear. The bench drives inputs on the falling edge and compares all three outputs on the following falling edge. That edge is half a period after the only register stage, so each comparison sees the result of one cycle's inputs. The reference model advances once for each driven cycle, so back-to-back adds are checked at the same one-cycle distance as isolated ones.

// File: rtl/shacc_pkg.sv
// Package: shared constants and types for the shifted-operand accumulator adder.
// Assumes the opcode sits in the upper byte of the instruction word.
package shacc_pkg;

    localparam int unsigned INSTR_W_DEF = 16;
    localparam int unsigned OPC_LSB     = 8;
    localparam logic [7:0]  OPC_SHACC   = 8'h63;

    // Classification of a signed overflow produced by the adder.
    typedef enum logic [1:0] {
        OVF_NONE = 2'b00,
        OVF_POS  = 2'b01,
        OVF_NEG  = 2'b10
    } ovf_kind_e;

endpackage

// File: rtl/shacc_decode.sv
// Module: shacc_decode
// Recognises the shifted-add instruction from its opcode byte.
// Assumes the addressing-mode fields in the low byte are handled elsewhere,
// so they do not take part in the match.
module shacc_decode
    import shacc_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF
) (
    input  logic               valid_in,
    input  logic [INSTR_W-1:0] instr,
    output logic               hit
);

    localparam int unsigned OPC_W = INSTR_W - OPC_LSB;

    logic [OPC_W-1:0]   opc_field;
    logic [OPC_LSB-1:0] unused_addr_field;

    // Split the word into the opcode byte and the addressing field.
    always_comb begin
        opc_field         = instr[INSTR_W-1:OPC_LSB];
        unused_addr_field = instr[OPC_LSB-1:0];
    end

    // Fire only on a valid word carrying the expected opcode.
    always_comb begin
        hit = valid_in && (opc_field == OPC_W'(OPC_SHACC));
    end

endmodule

// File: rtl/shacc_shifter.sv
// Module: shacc_shifter
// Extends the data operand to accumulator width (sign or zero fill) and
// shifts it left by a run-time amount; bits beyond the top are dropped.
// Assumes ACC_W > DATA_W.
module shacc_shifter #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned SHIFT_W = 4
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               sxm,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [ACC_W-1:0]   operand
);

    localparam int unsigned EXT_W = ACC_W - DATA_W;

    logic             fill_bit;
    logic [ACC_W-1:0] extended;
    logic [ACC_W-1:0] low_mask;

    // Choose the fill bit from the sign-extension mode.
    always_comb begin
        fill_bit = sxm & data[DATA_W-1];
        extended = {{EXT_W{fill_bit}}, data};
    end

    // Apply the left shift by the run-time amount.
    always_comb begin
        operand = extended << shamt;
    end

    // Mask of the positions the shift must have vacated.
    always_comb begin
        low_mask = ~({ACC_W{1'b1}} << shamt);
    end

    // R4: the vacated low bits of the shifted operand must be zero.
    always_comb begin
        if (!$isunknown({data, sxm, shamt})) begin
            a_r4_low_bits_clear: assert ((operand & low_mask) == '0)
                else $error("shifted operand has nonzero vacated bits");
        end
    end

endmodule

// File: rtl/shacc_adder.sv
// Module: shacc_adder
// Adds the shifted operand to the accumulator, reports the unsigned carry
// and classifies signed overflow, then picks the saturated or wrapped sum.
// Assumes both inputs are two's-complement values of ACC_W bits.
module shacc_adder
    import shacc_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input  logic [ACC_W-1:0] acc_q,
    input  logic [ACC_W-1:0] operand,
    input  logic             ovm,
    output logic [ACC_W-1:0] acc_next,
    output logic             carry_out,
    output ovf_kind_e        ovf_kind
);

    localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   wide_sum;
    logic [ACC_W-1:0] raw_sum;
    logic             same_sign;
    logic             sign_flip;

    // Full-width unsigned addition with the carry kept.
    always_comb begin
        wide_sum  = {1'b0, acc_q} + {1'b0, operand};
        raw_sum   = wide_sum[ACC_W-1:0];
        carry_out = wide_sum[ACC_W];
    end

    // Signed overflow: equal input signs, result sign differs.
    always_comb begin
        same_sign = (acc_q[ACC_W-1] == operand[ACC_W-1]);
        sign_flip = (raw_sum[ACC_W-1] != acc_q[ACC_W-1]);
        if (same_sign && sign_flip) begin
            ovf_kind = acc_q[ACC_W-1] ? OVF_NEG : OVF_POS;
        end else begin
            ovf_kind = OVF_NONE;
        end
    end

    // Select saturation or the wrapped sum according to the mode.
    always_comb begin
        unique case (ovf_kind)
            OVF_POS: acc_next = ovm ? SAT_POS : raw_sum;
            OVF_NEG: acc_next = ovm ? SAT_NEG : raw_sum;
            default: acc_next = raw_sum;
        endcase
    end

endmodule

// File: rtl/shacc_unit.sv
// Module: shacc_unit (top)
// Execute-stage unit for the add-with-run-time-shift instruction. Holds the
// accumulator, carry flag and sticky overflow flag; updates them on the rising
// edge after a valid matching instruction. Synchronous active-low reset.
// Assumes the data word for the instruction arrives in the same cycle.
module shacc_unit
    import shacc_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  data_in,
    input  logic [DATA_W-1:0]  treg,
    input  logic               sxm,
    input  logic               ovm,
    input  logic               ov_clear,
    output logic [ACC_W-1:0]   acc,
    output logic               carry,
    output logic               ov
);

    localparam logic [ACC_W-1:0] SAT_POS_CHK = {1'b0, {(ACC_W-1){1'b1}}};

    logic                   hit;
    logic [SHIFT_W-1:0]     shamt;
    logic [DATA_W-SHIFT_W-1:0] unused_treg_hi;
    logic [ACC_W-1:0]       operand;
    logic [ACC_W-1:0]       acc_next;
    logic                   carry_out;
    ovf_kind_e              ovf_kind;
    logic                   ovf_hit;

    // Shift amount comes from the low bits of the temporary register only.
    always_comb begin
        shamt          = treg[SHIFT_W-1:0];
        unused_treg_hi = treg[DATA_W-1:SHIFT_W];
    end

    shacc_decode #(
        .INSTR_W (INSTR_W)
    ) u_decode (
        .valid_in (valid_in),
        .instr    (instr),
        .hit      (hit)
    );

    shacc_shifter #(
        .DATA_W  (DATA_W),
        .ACC_W   (ACC_W),
        .SHIFT_W (SHIFT_W)
    ) u_shifter (
        .data    (data_in),
        .sxm     (sxm),
        .shamt   (shamt),
        .operand (operand)
    );

    shacc_adder #(
        .ACC_W (ACC_W)
    ) u_adder (
        .acc_q     (acc),
        .operand   (operand),
        .ovm       (ovm),
        .acc_next  (acc_next),
        .carry_out (carry_out),
        .ovf_kind  (ovf_kind)
    );

    // An executed add that overflows.
    always_comb begin
        ovf_hit = hit && (ovf_kind != OVF_NONE);
    end

    // Accumulator and carry register: load on an executed add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            carry <= 1'b0;
        end else if (hit) begin
            acc   <= acc_next;
            carry <= carry_out;
        end
    end

    // Sticky overflow flag: a new overflow wins over an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov <= 1'b0;
        end else if (ovf_hit) begin
            ov <= 1'b1;
        end else if (ov_clear) begin
            ov <= 1'b0;
        end
    end

    // R3: no executed add leaves accumulator and carry untouched.
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(acc) && $stable(carry)));

    // R6: adding a zero operand yields no carry and no change.
    a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && operand == '0) |=> (!carry && $stable(acc)));

    // R7: an overflowing add raises the flag.
    a_r7_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> ov);

    // R7: the flag stays up while no clear is requested.
    a_r7_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ov && !ov_clear) |=> ov);

    // R8: a clear without a coinciding overflow drops the flag.
    a_r8_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_clear && !ovf_hit) |=> !ov);

    // R9: saturation mode pins a positive overflow to the maximum.
    a_r9_sat_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ovm && ovf_kind == OVF_POS) |=> (acc == SAT_POS_CHK));

    // R10: wrap mode lets a positive overflow turn the sign negative.
    a_r10_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ovm && ovf_kind == OVF_POS) |=> acc[ACC_W-1]);

endmodule

// File: tb/shacc_unit_bench.sv
`timescale 1ns/1ps
module shacc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] data_in = '0;
    logic [15:0] treg = '0;
    logic        sxm = 1'b0;
    logic        ovm = 1'b0;
    logic        ov_clear = 1'b0;
    logic [31:0] acc;
    logic        carry;
    logic        ov;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_acc = '0;
    logic        m_carry = 1'b0;
    logic        m_ov = 1'b0;

    always #2 clk = ~clk;

    shacc_unit u_shacc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (valid_in),
        .instr    (instr),
        .data_in  (data_in),
        .treg     (treg),
        .sxm      (sxm),
        .ovm      (ovm),
        .ov_clear (ov_clear),
        .acc      (acc),
        .carry    (carry),
        .ov       (ov)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Reference model of one edge, written from the requirements.
    task automatic model(input logic v, input logic [15:0] ins, input logic [15:0] d,
                         input logic [15:0] t, input logic sx, input logic om,
                         input logic clr);
        logic [31:0] ext;
        logic [31:0] op;
        logic [32:0] s;
        logic        of;
        ext = sx ? {{16{d[15]}}, d} : {16'h0000, d};
        op  = ext << t[3:0];
        s   = {1'b0, m_acc} + {1'b0, op};
        of  = (m_acc[31] == op[31]) && (s[31] != m_acc[31]);
        if (v && ins[15:8] == 8'h63) begin
            m_carry = s[32];
            if (of && om) m_acc = m_acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else          m_acc = s[31:0];
            if (of)       m_ov = 1'b1;
            else if (clr) m_ov = 1'b0;
        end else if (clr) begin
            m_ov = 1'b0;
        end
    endtask

    // Drive one cycle at the falling edge, compare after the next rising edge.
    task automatic step(input string tag, input logic v, input logic [15:0] ins,
                        input logic [15:0] d, input logic [15:0] t, input logic sx,
                        input logic om, input logic clr);
        valid_in = v; instr = ins; data_in = d; treg = t;
        sxm = sx; ovm = om; ov_clear = clr;
        model(v, ins, d, t, sx, om, clr);
        @(negedge clk);
        chk(tag, "acc", acc, m_acc);
        chk(tag, "carry", {31'b0, carry}, {31'b0, m_carry});
        chk(tag, "ov", {31'b0, ov}, {31'b0, m_ov});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; valid_in = 1'b1; instr = 16'h6300; data_in = 16'h1234;
        treg = '0; sxm = 1'b0; ovm = 1'b0; ov_clear = 1'b0;
        repeat (2) @(negedge clk);
        m_acc = '0; m_carry = 1'b0; m_ov = 1'b0;
        chk("R1", "acc", acc, 32'h0);
        chk("R1", "carry", {31'b0, carry}, 32'h0);
        chk("R1", "ov", {31'b0, ov}, 32'h0);
        rst_n = 1'b1; valid_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // R2: direct and indirect forms, address fields irrelevant.
        step("R2 direct", 1, 16'h6355, 16'h0001, 16'h0000, 0, 0, 0);
        step("R2 indirect", 1, 16'h638F, 16'h0002, 16'h0000, 0, 0, 0);
        step("R2 indirect", 1, 16'h63F3, 16'h0004, 16'h0001, 0, 0, 0);
        // R3: wrong opcode and missing strobe.
        step("R3 opcode", 1, 16'h6455, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R3 novalid", 0, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 0);
        // R4: upper treg bits ignored, overflowed bits discarded.
        step("R4 treg_hi", 1, 16'h6300, 16'h0001, 16'hFFF4, 0, 0, 0);
        do_reset();
        step("R4 shift15", 1, 16'h6300, 16'h8000, 16'h000F, 1, 0, 0);
        do_reset();
        // R5: sign versus zero extension.
        step("R5 zero", 1, 16'h6300, 16'h8000, 16'h0000, 0, 0, 0);
        do_reset();
        step("R5 sign", 1, 16'h6300, 16'h8000, 16'h0000, 1, 0, 0);
        // R6: carry set then cleared.
        step("R6 setup", 1, 16'h6300, 16'hFFFF, 16'h0000, 1, 0, 0);
        step("R6 carry", 1, 16'h6300, 16'h0001, 16'h0000, 0, 0, 0);
        step("R6 nocarry", 1, 16'h6300, 16'h0000, 16'h0000, 0, 0, 0);
        // R10/R7: positive overflow wraps and sets the sticky flag.
        do_reset();
        step("R11 b2b", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R11 b2b", 1, 16'h6380, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R10 wrap", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R7 sticky", 1, 16'h6300, 16'h0000, 16'h0000, 0, 0, 0);
        step("R7 sticky", 0, 16'h0000, 16'h0000, 16'h0000, 0, 0, 0);
        // R8: clear alone, then clear racing a new overflow.
        step("R8 clear", 0, 16'h0000, 16'h0000, 16'h0000, 0, 0, 1);
        do_reset();
        step("R8 setup", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R8 setup", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 0);
        step("R8 race", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 0, 1);
        // R9: positive saturation.
        do_reset();
        step("R9 setup", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 1, 0);
        step("R9 setup", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 1, 0);
        step("R9 satpos", 1, 16'h6300, 16'h7FFF, 16'h000F, 0, 1, 0);
        // R9: negative saturation with carry still reported (R6).
        do_reset();
        step("R9 setup", 1, 16'h6300, 16'h8000, 16'h000F, 1, 1, 0);
        step("R9 setup", 1, 16'h6300, 16'h8000, 16'h000F, 1, 1, 0);
        step("R9 satneg R6", 1, 16'h6300, 16'h8000, 16'h000F, 1, 1, 0);

        // R11: random back-to-back traffic against the model.
        do_reset();
        for (int i = 0; i < 800; i++) begin
            logic [15:0] ins;
            ins = $urandom();
            if ($urandom_range(9) < 6) ins[15:8] = 8'h63;
            step("R11 random", ($urandom_range(9) < 8), ins, 16'($urandom()),
                 16'($urandom()), 1'($urandom()), 1'($urandom()),
                 ($urandom_range(9) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule